// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Offset Controller

This block produces the almost-empty and almost-full indications of a FIFO from a word count that the surrounding FIFO supplies, and it owns the two offset thresholds those indications are compared against. The FIFO storage itself lies outside the block. While the master reset is held, a load pin and a two-bit select bus are sampled. Together they pick one of eight preset thresholds, and the load pin on its own decides whether the thresholds are later rewritten through a one-bit serial input or through a parallel word port.

After reset, the load pin acts as an access gate. While it is low, write strobes load the thresholds and read strobes return them, and ordinary FIFO transfers are held off. While it is high, the FIFO's own write and read strobes pass through, and the thresholds keep their values. Each time load goes high, the serial and parallel access sequences start again from the almost-empty threshold.

Top module: `almost_flag_ctrl`

## Requirements
- R1: The preset index is {ld, fsel[1], fsel[0]}, with ld as the most significant bit, sampled while reset is held. Both thresholds then equal 2^(index+3)-1, which gives 7 for index 0 and 1023 for index 7.
- R2: A low ld during reset selects serial programming. A high ld during reset selects parallel programming.
- R3: In serial mode, each clock with wr_en high and ld low shifts sdat in. Bits 0..OFS_W-1 fill the almost-empty threshold, least significant bit first, and the next OFS_W bits fill the almost-full threshold. The bit position returns to the first almost-empty bit whenever ld is high.
- R4: In parallel mode, writes with ld low store pdin alternately: first into the almost-empty threshold, then into the almost-full threshold. The alternation restarts at almost-empty whenever ld is high.
- R5: A clock with rd_en high and ld low puts a threshold on ofs_rdata after that edge and raises ofs_rvalid for that one cycle. Successive reads return almost-empty, then almost-full, alternating, and the order restarts while ld is high.
- R6: pdin has no effect in serial mode, and sdat has no effect in parallel mode.
- R7: fifo_wr_ok equals wr_en and fifo_rd_ok equals rd_en only while ld is high and reset is over. Otherwise both are 0.
- R8: One clock after word_cnt is presented, almost_empty is 1 exactly when word_cnt is at or below the almost-empty threshold.
- R9: One clock after word_cnt is presented, almost_full is 1 exactly when DEPTH minus word_cnt is at or below the almost-full threshold.
- R10: During reset, almost_empty is 1, almost_full is 0, ofs_rvalid is 0, ofs_rdata is 0, and both FIFO enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| ld | input | 1 | Preset select bit during reset; offset access gate afterwards |
| fsel | input | 2 | Preset select bits sampled during reset |
| sdat | input | 1 | Serial threshold data |
| wr_en | input | 1 | Write strobe (FIFO write or threshold write) |
| rd_en | input | 1 | Read strobe (FIFO read or threshold read) |
| pdin | input | OFS_W | Parallel threshold write data |
| word_cnt | input | CNT_W | Words currently held by the FIFO (0..DEPTH) |
| fifo_wr_ok | output | 1 | Gated FIFO write enable |
| fifo_rd_ok | output | 1 | Gated FIFO read enable |
| ofs_rdata | output | OFS_W | Threshold read data |
| ofs_rvalid | output | 1 | ofs_rdata was loaded by a read in the previous cycle |
| almost_empty | output | 1 | Registered almost-empty flag |
| almost_full | output | 1 | Registered almost-full flag |

## Verification
On every cycle, the assertions check the following: a threshold read always produces a one-cycle valid pulse and nothing else does; both thresholds stay frozen while ld is high; the serial bit position stays in range; FIFO strobes are blocked while ld is low; and the flags react correctly at an empty and a completely full count. Only the bench's scenarios can show the rest. That covers the preset decoding for all eight index values, the bit and word order of serial and parallel loading, the fact that the unused data input is ignored in each mode, the restart of the access sequence, and the exact flag thresholds across a full sweep of word_cnt.

// File: rtl/aflo_pkg.sv
`timescale 1ns/1ps
package aflo_pkg;

  typedef enum logic {
    PROG_SERIAL   = 1'b0,
    PROG_PARALLEL = 1'b1
  } prog_mode_e;

  localparam int SEL_W      = 3;
  localparam int PRESET_LSH = 3;

  // preset threshold for a 3-bit index: 2^(idx+3)-1
  function automatic int unsigned preset_value(input logic [SEL_W-1:0] idx);
    int unsigned sh;
    sh = int'(idx) + PRESET_LSH;
    return (32'd1 << sh) - 32'd1;
  endfunction

endpackage

// File: rtl/aflo_rst_sync.sv
`timescale 1ns/1ps
module aflo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q_n = sh_q[STAGES-1];

endmodule

// File: rtl/aflo_cfg_cap.sv
`timescale 1ns/1ps
module aflo_cfg_cap
  import aflo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             ld,
  input  logic [1:0]       fsel,
  output prog_mode_e       mode,
  output logic [OFS_W-1:0] preset
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             sel_en;

  // capture the strap pins on every clock while reset is held
  always_comb begin
    sel_en = !rst_q_n;
    sel_d  = {ld, fsel};
  end

  always_ff @(posedge clk) begin
    if (sel_en) sel_q <= sel_d;
  end

  always_comb begin
    mode   = sel_q[SEL_W-1] ? PROG_PARALLEL : PROG_SERIAL;
    preset = OFS_W'(preset_value(sel_q));
  end

endmodule

// File: rtl/aflo_ofs_bank.sv
`timescale 1ns/1ps
module aflo_ofs_bank
  import aflo_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  prog_mode_e       mode,
  input  logic [OFS_W-1:0] preset,
  input  logic             ld,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             sdat,
  input  logic [OFS_W-1:0] pdin,
  output logic [OFS_W-1:0] ae_ofs,
  output logic [OFS_W-1:0] af_ofs,
  output logic [OFS_W-1:0] rdata,
  output logic             rvalid
);

  localparam int BITS  = 2 * OFS_W;
  localparam int PTR_W = $clog2(BITS);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(BITS - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             wsel_q, wsel_d;
  logic             rsel_q, rsel_d;
  logic [OFS_W-1:0] ae_q, ae_d;
  logic [OFS_W-1:0] af_q, af_d;
  logic [OFS_W-1:0] rdata_q, rdata_d;
  logic             rvalid_q, rvalid_d;

  logic acc_wr, acc_rd, ser_wr, par_wr;

  always_comb begin
    acc_wr = wr_en && !ld;
    acc_rd = rd_en && !ld;
    ser_wr = acc_wr && (mode == PROG_SERIAL);
    par_wr = acc_wr && (mode == PROG_PARALLEL);
  end

  // next state: bit position, word selectors, thresholds, read data
  always_comb begin
    ptr_d    = ptr_q;
    wsel_d   = wsel_q;
    rsel_d   = rsel_q;
    ae_d     = ae_q;
    af_d     = af_q;
    rdata_d  = rdata_q;
    rvalid_d = acc_rd;

    if (ld) begin
      ptr_d  = '0;
      wsel_d = 1'b0;
      rsel_d = 1'b0;
    end else begin
      if (ser_wr) begin
        ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end
      if (par_wr) wsel_d = ~wsel_q;
      if (acc_rd) rsel_d = ~rsel_q;
    end

    if (ser_wr) begin
      for (int i = 0; i < OFS_W; i++) begin
        if (ptr_q == PTR_W'(i))         ae_d[i] = sdat;
        if (ptr_q == PTR_W'(i + OFS_W)) af_d[i] = sdat;
      end
    end

    if (par_wr) begin
      if (wsel_q) af_d = pdin;
      else        ae_d = pdin;
    end

    if (acc_rd) rdata_d = rsel_q ? af_q : ae_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ptr_q    <= '0;
      wsel_q   <= 1'b0;
      rsel_q   <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      wsel_q   <= wsel_d;
      rsel_q   <= rsel_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  // thresholds take the preset while reset is held, the loaded values after
  always_ff @(posedge clk) begin
    if (!rst_q_n) begin
      ae_q <= preset;
      af_q <= preset;
    end else begin
      ae_q <= ae_d;
      af_q <= af_d;
    end
  end

  assign ae_ofs = ae_q;
  assign af_ofs = af_q;
  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  a_r5_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && !ld) |=> rvalid);

  a_r5_rvalid_needs_read: assert property (@(posedge clk) disable iff (!rst_q_n)
    rvalid |-> $past(rd_en && !ld));

  a_r4_ae_frozen_when_ld: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld && rst_q_n) |=> $stable(ae_ofs));

  a_r4_af_frozen_when_ld: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ld && rst_q_n) |=> $stable(af_ofs));

  a_r3_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_q_n)
    ptr_q <= PTR_LAST);

endmodule

// File: rtl/aflo_flag_cmp.sv
`timescale 1ns/1ps
module aflo_flag_cmp #(
  parameter int OFS_W = 10,
  parameter int DEPTH = 2048,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic [CNT_W-1:0] word_cnt,
  input  logic [OFS_W-1:0] ae_ofs,
  input  logic [OFS_W-1:0] af_ofs,
  output logic             almost_empty,
  output logic             almost_full
);

  localparam int CMP_W = (CNT_W > OFS_W) ? CNT_W : OFS_W;

  logic [CMP_W-1:0] cnt_x, free_x, ae_x, af_x;
  logic             ae_d, af_d, ae_q, af_q;

  always_comb begin
    cnt_x  = CMP_W'(word_cnt);
    free_x = CMP_W'(DEPTH) - cnt_x;
    ae_x   = CMP_W'(ae_ofs);
    af_x   = CMP_W'(af_ofs);
    ae_d   = (cnt_x <= ae_x);
    af_d   = (free_x <= af_x);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ae_q <= 1'b1;
      af_q <= 1'b0;
    end else begin
      ae_q <= ae_d;
      af_q <= af_d;
    end
  end

  assign almost_empty = ae_q;
  assign almost_full  = af_q;

  a_r8_empty_at_zero: assert property (@(posedge clk) disable iff (!rst_q_n)
    (word_cnt == '0) |=> almost_empty);

  a_r9_full_at_depth: assert property (@(posedge clk) disable iff (!rst_q_n)
    (word_cnt == CNT_W'(DEPTH)) |=> almost_full);

endmodule

// File: rtl/almost_flag_ctrl.sv
`timescale 1ns/1ps
module almost_flag_ctrl
  import aflo_pkg::*;
#(
  parameter int OFS_W      = 10,
  parameter int DEPTH      = 2048,
  parameter int CNT_W      = $clog2(DEPTH + 1),
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [1:0]       fsel,
  input  logic             sdat,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] pdin,
  input  logic [CNT_W-1:0] word_cnt,
  output logic             fifo_wr_ok,
  output logic             fifo_rd_ok,
  output logic [OFS_W-1:0] ofs_rdata,
  output logic             ofs_rvalid,
  output logic             almost_empty,
  output logic             almost_full
);

  logic             rst_q_n;
  prog_mode_e       mode;
  logic [OFS_W-1:0] preset;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  aflo_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  aflo_cfg_cap #(.OFS_W(OFS_W)) u_cfg (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .ld      (ld),
    .fsel    (fsel),
    .mode    (mode),
    .preset  (preset)
  );

  aflo_ofs_bank #(.OFS_W(OFS_W)) u_bank (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .mode    (mode),
    .preset  (preset),
    .ld      (ld),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .sdat    (sdat),
    .pdin    (pdin),
    .ae_ofs  (ae_ofs),
    .af_ofs  (af_ofs),
    .rdata   (ofs_rdata),
    .rvalid  (ofs_rvalid)
  );

  aflo_flag_cmp #(.OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_flag (
    .clk          (clk),
    .rst_q_n      (rst_q_n),
    .word_cnt     (word_cnt),
    .ae_ofs       (ae_ofs),
    .af_ofs       (af_ofs),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
  );

  // FIFO traffic passes only with load high and reset over
  always_comb begin
    fifo_wr_ok = wr_en && ld && rst_q_n;
    fifo_rd_ok = rd_en && ld && rst_q_n;
  end

  a_r7_wr_blocked_low_ld: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld |-> !fifo_wr_ok);

  a_r7_rd_blocked_low_ld: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld |-> !fifo_rd_ok);

endmodule

// File: tb/sim_almost_flag_ctrl.sv
`timescale 1ns/1ps
module sim_almost_flag_ctrl;

  localparam int OFS_W = 10;
  localparam int DEPTH = 2048;
  localparam int CNT_W = 12;

  logic             clk;
  logic             rst_n;
  logic             ld;
  logic [1:0]       fsel;
  logic             sdat;
  logic             wr_en;
  logic             rd_en;
  logic [OFS_W-1:0] pdin;
  logic [CNT_W-1:0] word_cnt;
  logic             fifo_wr_ok, fifo_rd_ok;
  logic [OFS_W-1:0] ofs_rdata;
  logic             ofs_rvalid, almost_empty, almost_full;

  int total = 0;
  int bad   = 0;

  almost_flag_ctrl #(.OFS_W(OFS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ld(ld), .fsel(fsel), .sdat(sdat),
    .wr_en(wr_en), .rd_en(rd_en), .pdin(pdin), .word_cnt(word_cnt),
    .fifo_wr_ok(fifo_wr_ok), .fifo_rd_ok(fifo_rd_ok),
    .ofs_rdata(ofs_rdata), .ofs_rvalid(ofs_rvalid),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int idx);
    rst_n = 1'b0; ld = idx[2]; fsel = idx[1:0];
    wr_en = 1'b1; rd_en = 1'b1; sdat = 1'b1; pdin = '1; word_cnt = '0;
    repeat (4) tick;
    chk(almost_empty == 1'b1, "R10 almost_empty in reset", almost_empty, 1);
    chk(almost_full == 1'b0,  "R10 almost_full in reset", almost_full, 0);
    chk(ofs_rvalid == 1'b0,   "R10 ofs_rvalid in reset", ofs_rvalid, 0);
    chk(ofs_rdata == '0,      "R10 ofs_rdata in reset", int'(ofs_rdata), 0);
    chk(!fifo_wr_ok && !fifo_rd_ok, "R10 fifo enables in reset",
        int'({fifo_wr_ok, fifo_rd_ok}), 0);
    wr_en = 1'b0; rd_en = 1'b0; sdat = 1'b0; pdin = '0;
    rst_n = 1'b1;
    repeat (3) tick;
    ld = 1'b1;
    tick;
  endtask

  task automatic read_pair(output int a, output int f);
    ld = 1'b0; rd_en = 1'b1;
    tick;
    chk(ofs_rvalid == 1'b1, "R5 rvalid after first read", ofs_rvalid, 1);
    a = int'(ofs_rdata);
    tick;
    chk(ofs_rvalid == 1'b1, "R5 rvalid after second read", ofs_rvalid, 1);
    f = int'(ofs_rdata);
    rd_en = 1'b0;
    tick;
    chk(ofs_rvalid == 1'b0, "R5 rvalid drops without read", ofs_rvalid, 0);
    ld = 1'b1;
    tick;
  endtask

  task automatic flag_sweep(input int ae, input int af);
    for (int c = 0; c <= DEPTH; c++) begin
      word_cnt = CNT_W'(c);
      tick;
      chk(almost_empty == (c <= ae), "R8 almost_empty", almost_empty, int'(c <= ae));
      chk(almost_full == ((DEPTH - c) <= af), "R9 almost_full", almost_full,
          int'((DEPTH - c) <= af));
    end
    word_cnt = '0;
  endtask

  task automatic serial_load(input int ae, input int af);
    ld = 1'b0; wr_en = 1'b1;
    for (int i = 0; i < 2 * OFS_W; i++) begin
      sdat = (i < OFS_W) ? ae[i] : af[i - OFS_W];
      pdin = OFS_W'(i * 37 + 5);
      tick;
    end
    wr_en = 1'b0; sdat = 1'b0; ld = 1'b1;
    tick;
  endtask

  initial begin
    int a, f, p, ea;
    #(4ns * 190000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int a, f, p, ea;
    // R1 and R2: every preset index
    for (int idx = 0; idx < 8; idx++) begin
      p = (1 << (idx + 3)) - 1;
      do_reset(idx);
      flag_sweep(p, p);
      read_pair(a, f);
      chk(a == p, "R1 preset almost-empty threshold", a, p);
      chk(f == p, "R1 preset almost-full threshold", f, p);
      // two write strobes with ld low; pdin 11/22, sdat 0
      ld = 1'b0; sdat = 1'b0; wr_en = 1'b1; pdin = 10'd11;
      tick;
      pdin = 10'd22;
      tick;
      wr_en = 1'b0; ld = 1'b1;
      tick;
      read_pair(a, f);
      if (idx >= 4) begin
        chk(a == 11, "R2 parallel mode word 0", a, 11);
        chk(f == 22, "R2 parallel mode word 1", f, 22);
      end else begin
        ea = p & ~3;
        chk(a == ea, "R2 serial mode shifted two zeros", a, ea);
        chk(f == p,  "R2 serial mode af untouched", f, p);
      end
    end

    // R3 and R6: serial load with a restart and pdin noise
    do_reset(2);
    ld = 1'b0; wr_en = 1'b1; sdat = 1'b1;
    repeat (3) tick;
    wr_en = 1'b0; ld = 1'b1;
    tick;
    serial_load(5, 300);
    read_pair(a, f);
    chk(a == 5,   "R3 serial almost-empty value", a, 5);
    chk(f == 300, "R3 serial almost-full value", f, 300);
    chk(a == 5 && f == 300, "R6 pdin ignored in serial mode", a + f, 305);
    flag_sweep(5, 300);

    // R4 and R6: parallel load with restart and sdat noise
    do_reset(6);
    ld = 1'b0; wr_en = 1'b1; sdat = 1'b1; pdin = 10'd50;
    tick;
    wr_en = 1'b0; ld = 1'b1;
    tick;
    ld = 1'b0; wr_en = 1'b1; pdin = 10'd60;
    tick;
    pdin = 10'd700;
    tick;
    wr_en = 1'b0; ld = 1'b1; sdat = 1'b0;
    tick;
    read_pair(a, f);
    chk(a == 60,  "R4 parallel restart to almost-empty", a, 60);
    chk(f == 700, "R4 parallel almost-full word", f, 700);
    chk(a == 60 && f == 700, "R6 sdat ignored in parallel mode", a + f, 760);
    flag_sweep(60, 700);

    // R5: read order restarts after ld high
    ld = 1'b0; rd_en = 1'b1;
    tick;
    rd_en = 1'b0; ld = 1'b1;
    tick;
    ld = 1'b0; rd_en = 1'b1;
    tick;
    chk(int'(ofs_rdata) == 60, "R5 read order restarts", int'(ofs_rdata), 60);
    rd_en = 1'b0; ld = 1'b1;
    tick;

    // R7: FIFO enable gating (checked between edges)
    ld = 1'b1; wr_en = 1'b1; rd_en = 1'b1;
    #1;
    chk(fifo_wr_ok == 1'b1, "R7 write passes with ld high", fifo_wr_ok, 1);
    chk(fifo_rd_ok == 1'b1, "R7 read passes with ld high", fifo_rd_ok, 1);
    ld = 1'b0;
    #0.5;
    chk(fifo_wr_ok == 1'b0, "R7 write blocked with ld low", fifo_wr_ok, 0);
    chk(fifo_rd_ok == 1'b0, "R7 read blocked with ld low", fifo_rd_ok, 0);
    ld = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    #0.5;
    chk(!fifo_wr_ok && !fifo_rd_ok, "R7 no strobe no enable",
        int'({fifo_wr_ok, fifo_rd_ok}), 0);
    tick;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule